// File: doc/BRIEF.md
# Framebuffer Fetch and Pixel Unpack Unit

This unit sits between a display timing generator and a word-wide memory port. It produces the read addresses that walk a linear framebuffer, one 32-bit word at a time, and holds the returned words in a short queue. It then hands one pixel per accepted request to the timing generator. All addresses are counted in halfwords. The upper bank bits of the start address stay fixed for the whole frame, and only the lower bits advance. A line is a fixed number of halfwords long. Between lines a programmable number of halfwords is skipped, so a visible window can be cut out of a wider image.

Two pixel formats are supported. In the narrow mode each byte is an index into a 256-entry table of 5:6:5 colours. In the wide mode each halfword is already a 5:6:5 colour. Before a word is split into pixels, its bytes can be reversed in the narrow mode, or its two halfwords exchanged in the wide mode. Lanes are then taken from least to most significant.

A start-of-frame pulse from the timing generator reloads the walk from the start address and empties the queue. The pulse must come while no read is outstanding, for example during vertical blanking once the previous frame has been fetched. The table is filled through a plain write port.

Top module: `pf_fetch_top`

## Requirements
- R1: While reset is held, and right after it, `mem_req`, `pix_valid` and `starve` are low.
- R2: The first cycle after a `frame_start` pulse presents `mem_addr` equal to `cfg_start_hw`. Every frame restarts from that address.
- R3: The top BANK_W bits of every requested address equal the top BANK_W bits of `cfg_start_hw`. Only the low LOW_W bits advance.
- R4: Requests advance by 2 halfwords within a line. Once `cfg_line_hw` halfwords of a line have been requested, the next line starts `cfg_line_hw + cfg_skip_hw` halfwords after the start of the previous line. With a skip of 0 the lines are contiguous. Start, line length and skip are even.
- R5: No request is made whose low address bits are at or above `cfg_end_low`. Every word below that bound in the walk is requested exactly once per frame.
- R6: While `mem_req` is high and `mem_ack` is low, the next cycle keeps `mem_req` high and `mem_addr` unchanged. A request is taken when both are high at a clock edge, and read data returns in order with `mem_rvalid`.
- R7: Words held in the queue plus reads in flight never exceed FIFO_DEPTH.
- R8: With `cfg_wide`=0, each word gives 4 pixels. Byte lane 0 (bits 7:0) comes first, and each byte is replaced by its table entry.
- R9: With `cfg_wide`=1, each word gives 2 pixels passed through unchanged. Bits 15:0 come first, then bits 31:16.
- R10: With `cfg_wide`=0 and `cfg_byte_swap`=1, the byte order is reversed, so bits 31:24 come first. `cfg_byte_swap` has no effect when `cfg_wide`=1.
- R11: With `cfg_wide`=1 and `cfg_half_swap`=1, bits 31:16 come first. `cfg_half_swap` has no effect when `cfg_wide`=0.
- R12: A `pix_req` that finds buffered data produces `pix_valid` with the pixel on the next cycle in both modes. `pix_valid` never rises without a `pix_req` one cycle earlier.
- R13: A `pix_req` that finds the queue empty raises `starve` for one cycle on the next cycle, with `pix_valid` low, and consumes no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Start-of-frame pulse from the timing generator |
| cfg_start_hw | input | BANK_W+LOW_W | Frame start address in halfwords, bank bits on top |
| cfg_end_low | input | LOW_W | Low bits of the frame end address in halfwords |
| cfg_line_hw | input | LOW_W | Visible line length in halfwords |
| cfg_skip_hw | input | LOW_W | Halfwords skipped between lines |
| cfg_wide | input | 1 | 1: 16-bit 5:6:5 pixels, 0: 8-bit table indices |
| cfg_byte_swap | input | 1 | Reverse byte order (narrow mode) |
| cfg_half_swap | input | 1 | Exchange halfwords (wide mode) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | BANK_W+LOW_W | Halfword address of the requested word |
| mem_ack | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| pal_we | input | 1 | Colour table write enable |
| pal_idx | input | 8 | Colour table write index |
| pal_color | input | 16 | Colour table write data (5:6:5) |
| pix_req | input | 1 | Timing generator asks for the next pixel |
| pix_valid | output | 1 | Pixel on pix_color is valid |
| pix_color | output | 16 | Pixel colour, 5:6:5 |
| starve | output | 1 | Pixel asked for while no data was buffered |

## Verification
The bench sweeps every combination of mode, both swap controls and a zero or non-zero line skip. It computes each request address and each pixel from the line arithmetic. A walk that forgot the skip, or lost the bank bits, shows up as a wrong address on the second line. A swap control that leaked into the other mode shows up as pixels in the wrong order. A frame whose end bound falls in the middle of a line checks that fetching stops on the exact word, neither one word short nor one word over. A queue without credit would overrun under the slow memory pattern. Requests made before any frame exercise starvation, where a faulty design would emit a stale pixel or advance its lane.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int WORD_W = 32;
  localparam int PIX_W  = 16;
  localparam int IDX_W  = 8;

  // Reorder the lanes of a fetched word so that lane 0 is always the first pixel.
  function automatic logic [WORD_W-1:0] lane_order(input logic [WORD_W-1:0] w,
                                                   input logic wide,
                                                   input logic bsw,
                                                   input logic hsw);
    if (wide)
      return hsw ? {w[15:0], w[31:16]} : w;
    else
      return bsw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  function automatic logic [IDX_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                 input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  function automatic logic [PIX_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                 input logic lane);
    return lane ? w[31:16] : w[15:0];
  endfunction

endpackage

// File: rtl/pf_addr_walk.sv
module pf_addr_walk #(
  parameter int LOW_W  = 21,
  parameter int BANK_W = 9,
  localparam int HW_W  = LOW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [HW_W-1:0]   start_hw,
  input  logic [LOW_W-1:0]  end_low,
  input  logic [LOW_W-1:0]  line_hw,
  input  logic [LOW_W-1:0]  skip_hw,
  input  logic              credit_ok,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [HW_W-1:0]   mem_addr,
  output logic              fire
);

  logic [LOW_W-1:0]  cur_q;
  logic [LOW_W-1:0]  col_q;
  logic [BANK_W-1:0] bank_q;
  logic              run_q;

  // True when the word at column col finishes the visible line.
  function automatic logic line_done(input logic [LOW_W-1:0] col,
                                     input logic [LOW_W-1:0] line);
    return ({1'b0, col} + (LOW_W+1)'(2)) >= {1'b0, line};
  endfunction

  function automatic logic [LOW_W-1:0] next_addr(input logic [LOW_W-1:0] cur,
                                                 input logic wrap,
                                                 input logic [LOW_W-1:0] skip);
    return cur + LOW_W'(2) + (wrap ? skip : '0);
  endfunction

  logic             wrap;
  logic [LOW_W-1:0] nxt;

  assign wrap     = line_done(col_q, line_hw);
  assign nxt      = next_addr(cur_q, wrap, skip_hw);
  assign mem_req  = run_q && credit_ok;
  assign fire     = mem_req && mem_ack;
  assign mem_addr = {bank_q, cur_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
      run_q  <= 1'b0;
    end else if (frame_start) begin
      cur_q  <= start_hw[LOW_W-1:0];
      bank_q <= start_hw[HW_W-1:LOW_W];
      col_q  <= '0;
      run_q  <= start_hw[LOW_W-1:0] < end_low;
    end else if (fire) begin
      cur_q  <= nxt;
      col_q  <= wrap ? '0 : col_q + LOW_W'(2);
      run_q  <= nxt < end_low;
    end
  end

endmodule

// File: rtl/pf_word_fifo.sv
module pf_word_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic [CW-1:0]    level
);

  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_push = push && (int'(cnt_q) < DEPTH) && !clear;
  assign do_pop  = pop && (cnt_q != '0) && !clear;

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign dout  = slot_q[rd_q];
  assign empty = (cnt_q == '0);
  assign level = cnt_q;

endmodule

// File: rtl/pf_lane_unpack.sv
module pf_lane_unpack
  import pf_pkg::*;
#(
  parameter int PAL_N = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  input  logic              empty,
  input  logic              wide,
  input  logic              bsw,
  input  logic              hsw,
  input  logic              pix_req,
  input  logic              pal_we,
  input  logic [IDX_W-1:0]  pal_idx,
  input  logic [PIX_W-1:0]  pal_color,
  output logic              pop,
  output logic              take,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_color,
  output logic              starve
);

  logic [PIX_W-1:0]  pal_mem [PAL_N];
  logic [1:0]        lane_q;
  logic [WORD_W-1:0] ordered;
  logic [IDX_W-1:0]  idx;
  logic [PIX_W-1:0]  half;
  logic              last;

  logic [PIX_W-1:0]  pal_q;
  logic [PIX_W-1:0]  half_q;
  logic              wide_q;

  assign ordered = lane_order(word, wide, bsw, hsw);
  assign idx     = pick_byte(ordered, lane_q);
  assign half    = pick_half(ordered, lane_q[0]);
  assign last    = wide ? lane_q[0] : (lane_q == 2'd3);
  assign take    = pix_req && !empty;
  assign pop     = take && last;

  always_ff @(posedge clk) begin
    if (pal_we) pal_mem[pal_idx] <= pal_color;
  end

  // Table read: the extra cycle that the wide path matches through half_q.
  always_ff @(posedge clk) begin
    pal_q <= pal_mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q    <= '0;
      half_q    <= '0;
      wide_q    <= 1'b0;
      pix_valid <= 1'b0;
      starve    <= 1'b0;
    end else begin
      half_q    <= half;
      wide_q    <= wide;
      pix_valid <= take && !clear;
      starve    <= pix_req && empty && !clear;
      if (clear)
        lane_q <= '0;
      else if (take)
        lane_q <= last ? 2'd0 : lane_q + 2'd1;
    end
  end

  assign pix_color = wide_q ? half_q : pal_q;

endmodule

// File: rtl/pf_fetch_top.sv
module pf_fetch_top
  import pf_pkg::*;
#(
  parameter int LOW_W      = 21,
  parameter int BANK_W     = 9,
  parameter int FIFO_DEPTH = 4,
  localparam int HW_W      = LOW_W + BANK_W,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [HW_W-1:0]   cfg_start_hw,
  input  logic [LOW_W-1:0]  cfg_end_low,
  input  logic [LOW_W-1:0]  cfg_line_hw,
  input  logic [LOW_W-1:0]  cfg_skip_hw,
  input  logic              cfg_wide,
  input  logic              cfg_byte_swap,
  input  logic              cfg_half_swap,
  output logic              mem_req,
  output logic [HW_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              pal_we,
  input  logic [IDX_W-1:0]  pal_idx,
  input  logic [PIX_W-1:0]  pal_color,
  input  logic              pix_req,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_color,
  output logic              starve
);

  // Named internal events, observed by the bound checker.
  logic              fire;
  logic              word_pop;
  logic              pix_take;
  logic              head_empty;
  logic [WORD_W-1:0] head_word;
  logic [CW-1:0]     fifo_level;
  logic [CW-1:0]     inflight_q;
  logic              credit_ok;

  assign credit_ok = (int'(fifo_level) + int'(inflight_q)) < FIFO_DEPTH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      inflight_q <= '0;
    else
      inflight_q <= inflight_q + CW'(fire) - CW'(mem_rvalid);
  end

  pf_addr_walk #(.LOW_W(LOW_W), .BANK_W(BANK_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .start_hw   (cfg_start_hw),
    .end_low    (cfg_end_low),
    .line_hw    (cfg_line_hw),
    .skip_hw    (cfg_skip_hw),
    .credit_ok  (credit_ok),
    .mem_ack    (mem_ack),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .fire       (fire)
  );

  pf_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(frame_start),
    .push (mem_rvalid),
    .din  (mem_rdata),
    .pop  (word_pop),
    .dout (head_word),
    .empty(head_empty),
    .level(fifo_level)
  );

  pf_lane_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (frame_start),
    .word     (head_word),
    .empty    (head_empty),
    .wide     (cfg_wide),
    .bsw      (cfg_byte_swap),
    .hsw      (cfg_half_swap),
    .pix_req  (pix_req),
    .pal_we   (pal_we),
    .pal_idx  (pal_idx),
    .pal_color(pal_color),
    .pop      (word_pop),
    .take     (pix_take),
    .pix_valid(pix_valid),
    .pix_color(pix_color),
    .starve   (starve)
  );

endmodule

// File: rtl/pf_fetch_chk.sv
module pf_fetch_chk #(
  parameter int LOW_W      = 21,
  parameter int BANK_W     = 9,
  parameter int FIFO_DEPTH = 4,
  localparam int HW_W      = LOW_W + BANK_W,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic [HW_W-1:0]  cfg_start_hw,
  input logic [LOW_W-1:0] cfg_end_low,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [HW_W-1:0]  mem_addr,
  input logic             pix_req,
  input logic             pix_valid,
  input logic             starve,
  input logic [CW-1:0]    level,
  input logic [CW-1:0]    inflight
);

  AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mem_addr == $past(cfg_start_hw))); // R2

  AST_BANK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[HW_W-1:LOW_W] == cfg_start_hw[HW_W-1:LOW_W])); // R3

  AST_BELOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[LOW_W-1:0] < cfg_end_low)); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !frame_start) |=> (mem_req && $stable(mem_addr))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) + int'(inflight)) <= FIFO_DEPTH); // R7

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(pix_req)); // R12

  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && !frame_start) |=> (pix_valid || starve)); // R12

  AST_STARVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    starve |-> (!pix_valid && $past(pix_req))); // R13

endmodule

bind pf_fetch_top pf_fetch_chk #(
  .LOW_W(LOW_W), .BANK_W(BANK_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .cfg_start_hw(cfg_start_hw),
  .cfg_end_low (cfg_end_low),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .pix_req     (pix_req),
  .pix_valid   (pix_valid),
  .starve      (starve),
  .level       (fifo_level),
  .inflight    (inflight_q)
);

// File: tb/sim_pf_fetch_top.sv
module sim_pf_fetch_top;

  localparam int LOW_W  = 21;
  localparam int BANK_W = 9;
  localparam int HW_W   = LOW_W + BANK_W;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic [HW_W-1:0]   cfg_start_hw = '0;
  logic [LOW_W-1:0]  cfg_end_low = '0;
  logic [LOW_W-1:0]  cfg_line_hw = '0;
  logic [LOW_W-1:0]  cfg_skip_hw = '0;
  logic              cfg_wide = 1'b0;
  logic              cfg_byte_swap = 1'b0;
  logic              cfg_half_swap = 1'b0;
  logic              mem_req;
  logic [HW_W-1:0]   mem_addr;
  logic              mem_ack = 1'b0;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;
  logic              pal_we = 1'b0;
  logic [7:0]        pal_idx = '0;
  logic [15:0]       pal_color = '0;
  logic              pix_req = 1'b0;
  logic              pix_valid;
  logic [15:0]       pix_color;
  logic              starve;

  pf_fetch_top #(.LOW_W(LOW_W), .BANK_W(BANK_W), .FIFO_DEPTH(DEPTH)) u0 (.*);

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory contents and table contents, both pure functions of the index.
  function automatic logic [31:0] mem_word(input int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [15:0] pal_val(input int i);
    return 16'(i * 257) ^ 16'hA5C3;
  endfunction

  // Frame configuration as seen by the bench model.
  int c_bank, c_start, c_end, c_line, c_skip;
  bit c_wide, c_bsw, c_hsw;

  function automatic int full_addr(input int low);
    return (c_bank << LOW_W) | low;
  endfunction

  // Low address of the n-th word request (R4).
  function automatic int req_low(input int n);
    int wpl = c_line / 2;
    return c_start + (n / wpl) * (c_line + c_skip) + 2 * (n % wpl);
  endfunction

  function automatic logic [15:0] exp_pixel(input int k);
    int ppw = c_wide ? 2 : 4;
    int ppl = c_wide ? c_line : 2 * c_line;
    int ln  = k / ppl;
    int x   = k % ppl;
    int wa  = c_start + ln * (c_line + c_skip) + (x / ppw) * 2;
    int lane = x % ppw;
    logic [31:0] w = mem_word(full_addr(wa));
    if (c_wide) begin
      if (c_hsw) lane = 1 - lane;
      return w[16*lane +: 16];
    end else begin
      if (c_bsw) lane = 3 - lane;
      return pal_val(int'(w[8*lane +: 8]));
    end
  endfunction

  function automatic string pix_tag();
    if (c_wide) return c_hsw ? "R11" : (c_bsw ? "R9/R10 byte swap ignored" : "R9");
    else        return c_bsw ? "R10" : (c_hsw ? "R8/R11 half swap ignored" : "R8");
  endfunction

  // Bench-side run state.
  bit running = 0;
  bit consume = 0;
  int cyc = 0;
  int rq = 0;
  int pk = 0;
  int exp_words = 0;
  int n_starve = 0;
  bit prev_pix_req = 0;
  bit hold_pending = 0;
  logic [HW_W-1:0] hold_addr;
  int q_addr[$];
  int q_time[$];

  always @(negedge clk) begin
    if (running) begin
      cyc++;
      // Outputs produced by the previous edge.
      if (prev_pix_req)
        check(pix_valid ^ starve, "R12 one outcome per request", {pix_valid, starve}, 2'b10);
      else
        check(!pix_valid && !starve, "R12 no output without request", {pix_valid, starve}, 0);
      if (starve) n_starve++;
      if (pix_valid) begin
        check(pix_color == exp_pixel(pk), pix_tag(), pix_color, exp_pixel(pk));
        pk++;
      end
      if (hold_pending)
        check(mem_req && mem_addr == hold_addr, "R6", mem_addr, hold_addr);
      hold_pending = 0;
      check(rq - pk / (c_wide ? 2 : 4) <= DEPTH, "R7", rq - pk / (c_wide ? 2 : 4), DEPTH);

      // Drive the memory side for the coming edge.
      mem_ack = (cyc % 5 != 3);
      if (mem_req) begin
        check(rq < exp_words, "R5 request beyond end", rq, exp_words);
        check(int'(mem_addr) == full_addr(req_low(rq)), "R4/R3 request address",
              mem_addr, full_addr(req_low(rq)));
        if (mem_ack) begin
          q_addr.push_back(int'(mem_addr));
          q_time.push_back(cyc);
          rq++;
        end else begin
          hold_pending = 1;
          hold_addr = mem_addr;
        end
      end
      mem_rvalid = 1'b0;
      if (q_addr.size() > 0 && (cyc - q_time[0]) >= 2 && (cyc % 3 != 1)) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(q_addr[0]);
        void'(q_addr.pop_front());
        void'(q_time.pop_front());
      end
      pix_req = consume && (cyc % 4 != 0);
      prev_pix_req = pix_req;
    end
  end

  task automatic run_frame(input int bank, input int start, input int line, input int skip,
                           input int end_low, input bit wide, input bit bsw, input bit hsw);
    int exp_pix;
    int guard;
    @(negedge clk);
    c_bank = bank; c_start = start; c_line = line; c_skip = skip; c_end = end_low;
    c_wide = wide; c_bsw = bsw; c_hsw = hsw;
    cfg_start_hw  = HW_W'((bank << LOW_W) | start);
    cfg_end_low   = LOW_W'(end_low);
    cfg_line_hw   = LOW_W'(line);
    cfg_skip_hw   = LOW_W'(skip);
    cfg_wide      = wide;
    cfg_byte_swap = bsw;
    cfg_half_swap = hsw;
    exp_words = 0;
    while (req_low(exp_words) < end_low) exp_words++;
    exp_pix = exp_words * (wide ? 2 : 4);
    rq = 0; pk = 0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(int'(mem_addr) == full_addr(start), "R2 reload", mem_addr, full_addr(start));
    consume = 1;
    guard = 0;
    while (pk < exp_pix && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    consume = 0;
    repeat (6) @(negedge clk);
    check(pk == exp_pix, wide ? "R9 pixel count" : "R8 pixel count", pk, exp_pix);
    check(rq == exp_words, "R5 word count", rq, exp_words);
    check(!mem_req, "R5 fetch stopped", mem_req, 0);
  endtask

  initial begin
    int skips[2];
    skips[0] = 0;
    skips[1] = 4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_req && !pix_valid && !starve, "R1", {mem_req, pix_valid, starve}, 0);
    for (int i = 0; i < 256; i++) begin
      pal_we = 1'b1; pal_idx = 8'(i); pal_color = pal_val(i);
      @(negedge clk);
    end
    pal_we = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !pix_valid && !starve, "R1 after release", {mem_req, pix_valid, starve}, 0);
    c_line = 4; c_wide = 0; exp_words = 0;
    running = 1;

    // Starvation before any frame: every request finds the queue empty.
    n_starve = 0;
    consume = 1;
    repeat (8) @(negedge clk);
    consume = 0;
    repeat (2) @(negedge clk);
    check(n_starve > 0 && pk == 0, "R13 starve without data", n_starve, 6);

    // Full sweep over mode, both swaps and line skip.
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 2; b++)
        for (int h = 0; h < 2; h++)
          for (int s = 0; s < 2; s++)
            run_frame(5, 16'h0040, 4, skips[s], 16'h0040 + 3 * (4 + skips[s]) - skips[s],
                      bit'(w), bit'(b), bit'(h));

    // End bound in the middle of a line, longer line, other bank.
    run_frame(3, 16'h0100, 4, 4, 16'h010A, 1'b0, 1'b0, 1'b0);
    run_frame(3, 16'h0100, 6, 2, 16'h0100 + 6 + 2 + 4, 1'b1, 1'b0, 1'b1);
    run_frame(0, 16'h0000, 8, 0, 16'h0020, 1'b0, 1'b1, 1'b0);

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule